// File: doc/BRIEF.md
# Self-Clocked One-Wire Bit Link

This block sends and receives bytes over a single wire that carries no clock. The line rests low. Every bit opens with a driven rising edge, and the time the line then stays high carries the bit value: a long high phase is a one and a short high phase is a zero. The bit rate is not fixed. Each message opens with two rate-setting pulses, and the receiver times them and uses that bit period for every later bit of the same message.

The transmit side takes one byte per start strobe, most significant bit first. It places the two rate-setting pulses in front of the byte when the caller marks that byte as the first of a message. The receive side brings the line into the clock domain, measures the period from the rate-setting pulses, samples each later bit half a period after its rising edge and hands over whole bytes. A line that stays low for too long ends the message. This is reported as an error when it happens inside a byte, and as a normal close when it happens between bytes. Message framing, addressing, checksums and the pad driver sit outside this block.

Top module: `pulsewire_link`

## Requirements
- R1: Out of reset, line_out is 0, tx_busy and tx_done are 0, and rx_valid, rx_timeout and rx_active are 0.
- R2: A transmitted bit of period P cycles drives line_out high from the first cycle of the bit, for P - floor(P/4) cycles for a one and floor(P/4) cycles for a zero, then low until the bit's P cycles end.
- R3: A tx_period below MIN_PERIOD (8) is raised to MIN_PERIOD for the whole message.
- R4: With tx_new_msg = 1 the byte is preceded by two zero bits and tx_busy lasts 10·P cycles. With tx_new_msg = 0 no such bits are sent and tx_busy lasts 8·P cycles.
- R5: Data bits go out most significant bit first, and rx_byte presents them in the same bit order as tx_byte.
- R6: tx_done is a one-cycle pulse in the cycle after the last bit period, in which tx_busy is already 0. line_out stays 0 while tx_busy is 0.
- R7: A tx_start while tx_busy is 1 is ignored: the running byte and its length are unchanged.
- R8: The receiver sets rx_period to half the number of cycles between the first and third rising edges of a message. For a message sent by this block, that value equals the sender's effective period.
- R9: Each data bit is read as the line level floor(rx_period/2) cycles after its rising edge (high = 1). After the eighth bit, rx_valid pulses for one cycle with the byte on rx_byte.
- R10: Further bytes of the same message, sent with tx_new_msg = 0, are received with the period already measured.
- R11: If the line stays low for more than 2·rx_period cycles after one to seven bits of a byte, rx_timeout pulses once, the partial byte is discarded without an rx_valid, and rx_active drops.
- R12: If the line stays low for more than 2·rx_period cycles at a byte boundary, rx_active drops without an rx_timeout, and the next message is timed afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_start | input | 1 | Start sending tx_byte (taken only when idle) |
| tx_new_msg | input | 1 | Byte opens a message: send rate-setting pulses first |
| tx_byte | input | DATA_W | Byte to send |
| tx_period | input | CNT_W | Bit period in clock cycles |
| tx_busy | output | 1 | Transmitter is sending |
| tx_done | output | 1 | One-cycle strobe after the last bit period |
| line_out | output | 1 | Transmit level for the wire |
| line_in | input | 1 | Wire level seen by the receiver (asynchronous) |
| rx_byte | output | DATA_W | Received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe: rx_byte complete |
| rx_timeout | output | 1 | One-cycle strobe: line stuck low inside a byte |
| rx_period | output | CNT_W | Bit period measured for the current message |
| rx_active | output | 1 | Receiver is inside a message |

## Verification
The bench uses the default parameters: CNT_W = 12, DATA_W = 8, MIN_PERIOD = 8 and SYNC_STAGES = 2. Keeping periods between 8 and 20 cycles lets one run cover several cases: the raise of a too-short period, a period of 9 cycles where the quarter and half lengths round down, and back-to-back bytes inside one message. At these periods the low-line limits are reached within a few dozen cycles. The bench can also drive line_in by itself instead of looping it back. This lets it cut a byte short to force a timeout and end a message cleanly at a byte boundary.

// File: rtl/pw_pkg.sv
// Package: shared constants and types for the one-wire bit link.
// Assumes: nothing; holds no logic.
package pw_pkg;
    // number of rate-setting zero bits that open each message (averaged by shift)
    localparam int NEG_BITS = 2;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_MEAS = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;
endpackage

// File: rtl/pw_tx.sv
// Module: pw_tx
// Serialises one byte per start strobe onto the wire, MSB first. Each bit
// begins high; the high phase is three quarters of the period for a one and
// a quarter for a zero. A new message is prefixed with rate-setting zeros.
// Assumes: period of at least MIN_PER after clamping; start is only taken idle.
module pw_tx #(
    parameter int CNT_W   = 12,
    parameter int DATA_W  = 8,
    parameter int MIN_PER = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              new_msg,
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  period,
    output logic              busy,
    output logic              done,
    output logic              line
);
    localparam int FRAME_W = DATA_W + pw_pkg::NEG_BITS;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    logic                busy_q;
    logic                done_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    per_q;
    logic [LEFT_W-1:0]   left_q;
    logic [FRAME_W-1:0]  sh_q;

    logic [CNT_W-1:0]    eff_per;
    logic [CNT_W-1:0]    quarter;
    logic [CNT_W-1:0]    high_len;
    logic                cur_bit;

    // clamp the requested period to the supported minimum
    always_comb eff_per = (period < CNT_W'(MIN_PER)) ? CNT_W'(MIN_PER) : period;

    // high-phase length for the bit now on the wire
    always_comb begin
        cur_bit  = sh_q[FRAME_W-1];
        quarter  = per_q >> 2;
        high_len = cur_bit ? (per_q - quarter) : quarter;
    end

    // bit sequencer: load, count each period, shift, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            per_q  <= CNT_W'(MIN_PER);
            left_q <= '0;
            sh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    per_q  <= eff_per;
                    if (new_msg) begin
                        sh_q   <= {{pw_pkg::NEG_BITS{1'b0}}, data};
                        left_q <= LEFT_W'(FRAME_W);
                    end else begin
                        sh_q   <= {data, {pw_pkg::NEG_BITS{1'b0}}};
                        left_q <= LEFT_W'(DATA_W);
                    end
                end
            end else if (cnt_q == per_q - 1'b1) begin
                cnt_q <= '0;
                if (left_q == LEFT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    left_q <= left_q - 1'b1;
                    sh_q   <= sh_q << 1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign line = busy_q && (cnt_q < high_len);
endmodule

// File: rtl/pw_sync.sv
// Module: pw_sync
// Brings the asynchronous wire level into the clock domain through a flop
// chain and flags the cycle in which the synchronised level rises.
// Assumes: STAGES of at least 2; the same delay on rising and falling edges.
module pw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // synchroniser chain and previous-level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pw_rx.sv
// Module: pw_rx
// Times the rate-setting pulses of each message, then samples every data bit
// half a measured period after its rising edge and assembles MSB-first bytes.
// A low line longer than two periods ends the message (error inside a byte).
// Assumes: synchronised level and rise flag from pw_sync.
module pw_rx #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              rise,
    output logic [DATA_W-1:0] byte_out,
    output logic              valid,
    output logic              timeout,
    output logic [CNT_W-1:0]  period,
    output logic              active
);
    import pw_pkg::*;

    localparam int TW = CNT_W + 1;
    localparam int LW = CNT_W + 2;
    localparam int BW = $clog2(DATA_W);

    rx_state_e          st_q;
    logic [TW-1:0]      tcnt_q;
    logic               seen_q;
    logic [CNT_W-1:0]   per_q;
    logic [CNT_W-1:0]   ph_q;
    logic               armed_q;
    logic [BW-1:0]      bitn_q;
    logic [DATA_W-1:0]  sh_q;
    logic [LW-1:0]      low_q;
    logic               valid_q;
    logic               tout_q;

    logic [CNT_W-1:0]   half;
    logic [LW-1:0]      limit;
    logic               stall;

    // derived sample point and low-line limit
    always_comb begin
        half  = per_q >> 1;
        limit = {1'b0, per_q, 1'b0};
        stall = (low_q > limit);
    end

    // length of the current low stretch, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)            low_q <= '0;
        else if (lvl)          low_q <= '0;
        else if (low_q != '1)  low_q <= low_q + 1'b1;
    end

    // receive state machine: measure, sample, assemble, time out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            tcnt_q  <= '0;
            seen_q  <= 1'b0;
            per_q   <= '0;
            ph_q    <= '0;
            armed_q <= 1'b0;
            bitn_q  <= '0;
            sh_q    <= '0;
            valid_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            tout_q  <= 1'b0;
            case (st_q)
                RX_IDLE: begin
                    if (rise) begin
                        st_q   <= RX_MEAS;
                        tcnt_q <= TW'(1);
                        seen_q <= 1'b0;
                    end
                end
                RX_MEAS: begin
                    if (rise && seen_q) begin
                        per_q   <= tcnt_q[TW-1:1];
                        st_q    <= RX_DATA;
                        ph_q    <= CNT_W'(1);
                        armed_q <= 1'b1;
                        bitn_q  <= '0;
                    end else if (rise) begin
                        seen_q <= 1'b1;
                        tcnt_q <= tcnt_q + 1'b1;
                    end else if (tcnt_q == '1) begin
                        st_q <= RX_IDLE;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (stall) begin
                        st_q    <= RX_IDLE;
                        armed_q <= 1'b0;
                        tout_q  <= (bitn_q != '0);
                        bitn_q  <= '0;
                    end else if (rise) begin
                        ph_q    <= CNT_W'(1);
                        armed_q <= 1'b1;
                    end else begin
                        if (ph_q != '1) ph_q <= ph_q + 1'b1;
                        if (armed_q && ph_q == half) begin
                            armed_q <= 1'b0;
                            sh_q    <= {sh_q[DATA_W-2:0], lvl};
                            if (bitn_q == BW'(DATA_W - 1)) begin
                                bitn_q  <= '0;
                                valid_q <= 1'b1;
                            end else begin
                                bitn_q <= bitn_q + 1'b1;
                            end
                        end
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign byte_out = sh_q;
    assign valid    = valid_q;
    assign timeout  = tout_q;
    assign period   = per_q;
    assign active   = (st_q != RX_IDLE);
endmodule

// File: rtl/pulsewire_link.sv
// Module: pulsewire_link
// Top of the one-wire bit link: transmitter, input synchroniser and receiver.
// Assumes: line_in is driven externally (often looped from line_out).
module pulsewire_link #(
    parameter int CNT_W       = 12,
    parameter int DATA_W      = 8,
    parameter int MIN_PERIOD  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              tx_new_msg,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [CNT_W-1:0]  tx_period,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              line_out,
    input  logic              line_in,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_timeout,
    output logic [CNT_W-1:0]  rx_period,
    output logic              rx_active
);
    logic s_lvl;
    logic s_rise;

    // transmit serialiser
    pw_tx #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MIN_PER(MIN_PERIOD)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .new_msg(tx_new_msg),
        .data(tx_byte), .period(tx_period), .busy(tx_busy), .done(tx_done),
        .line(line_out)
    );

    // input synchroniser and edge finder
    pw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .lvl(s_lvl), .rise(s_rise)
    );

    // receive deserialiser
    pw_rx #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .lvl(s_lvl), .rise(s_rise),
        .byte_out(rx_byte), .valid(rx_valid), .timeout(rx_timeout),
        .period(rx_period), .active(rx_active)
    );
endmodule

// File: rtl/pw_link_checker.sv
// Module: pw_link_checker
// Temporal checks on the link's ports, bound into pulsewire_link.
// Assumes: synchronous active-low reset.
module pw_link_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_busy,
    input logic tx_done,
    input logic line_out,
    input logic rx_valid,
    input logic rx_timeout,
    input logic rx_active
);
    // R2: a bit opens with the line driven high
    a_r2_bit_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> line_out);

    // R6: line rests low when not sending
    a_r6_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !line_out);

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    // R6: done follows the end of busy
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_busy && $past(tx_busy)));

    // R9: byte strobe lasts one cycle and occurs inside a message
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r9_valid_in_msg: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_active);

    // R11: a timeout leaves the receiver idle and delivers no byte
    a_r11_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> (!rx_active && !rx_valid));
endmodule

bind pulsewire_link pw_link_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_done(tx_done),
    .line_out(line_out), .rx_valid(rx_valid), .rx_timeout(rx_timeout),
    .rx_active(rx_active)
);

// File: tb/pulsewire_link_test.sv
module pulsewire_link_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 1'b0;
    logic        tx_new_msg = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic [11:0] tx_period = '0;
    logic        tx_busy, tx_done, line_out, line_in;
    logic [7:0]  rx_byte;
    logic        rx_valid, rx_timeout, rx_active;
    logic [11:0] rx_period;
    logic        use_ext = 1'b0;
    logic        ext_line = 1'b0;

    int checks = 0;
    int fails = 0;
    int vcount = 0;
    int tocount = 0;
    int hrun = 0;
    int last_high = 0;
    int wd = 0;
    logic [7:0] last_byte = '0;

    always #2 clk = ~clk;

    assign line_in = use_ext ? ext_line : line_out;

    pulsewire_link uut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_new_msg(tx_new_msg),
        .tx_byte(tx_byte), .tx_period(tx_period), .tx_busy(tx_busy),
        .tx_done(tx_done), .line_out(line_out), .line_in(line_in),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_timeout(rx_timeout),
        .rx_period(rx_period), .rx_active(rx_active)
    );

    // {new_msg, period[11:0], byte[7:0]}
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 12'd8,  8'hA5},
        {1'b0, 12'd8,  8'h3C},
        {1'b1, 12'd12, 8'h00},
        {1'b0, 12'd12, 8'hFF},
        {1'b0, 12'd12, 8'h81},
        {1'b1, 12'd9,  8'h6B},
        {1'b1, 12'd4,  8'hC3},
        {1'b1, 12'd20, 8'h5A}
    };

    // port monitor: byte strobes, timeouts and the length of each high pulse
    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            last_byte = rx_byte;
        end
        if (rx_timeout) tocount++;
        if (line_out) hrun++;
        else if (hrun != 0) begin
            last_high = hrun;
            hrun = 0;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // watchdog
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", wd);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // send one byte, return busy-cycle count; optionally poke start mid-way
    task automatic send(input bit nm, input logic [11:0] p, input logic [7:0] b,
                        input int poke_at, output int busy_cnt, output int done_cnt);
        busy_cnt = 0;
        done_cnt = 0;
        tx_new_msg = nm;
        tx_period  = p;
        tx_byte    = b;
        tx_start   = 1'b1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            tx_start = (c == poke_at);
            if (c == poke_at) begin
                tx_byte    = ~b;
                tx_new_msg = 1'b1;
            end
            if (tx_done) begin
                done_cnt++;
                break;
            end
            if (tx_busy) busy_cnt++;
        end
        tx_start = 1'b0;
        @(negedge clk);
        if (tx_done) done_cnt++;
        chk(line_out == 1'b0, "R6 line low after done", int'(line_out), 0);
    endtask

    task automatic ext_bit(input int p, input bit b);
        int h;
        h = b ? (p - p / 4) : (p / 4);
        for (int c = 0; c < p; c++) begin
            ext_line = (c < h);
            @(negedge clk);
        end
    endtask

    initial begin
        int bc, dc, v0, t0, peff, nb;
        bit nm;
        logic [11:0] p;
        logic [7:0] b;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(line_out == 0, "R1 line_out", int'(line_out), 0);
        chk(tx_busy == 0 && tx_done == 0, "R1 tx idle", int'({tx_busy, tx_done}), 0);
        chk(rx_valid == 0 && rx_timeout == 0 && rx_active == 0, "R1 rx idle",
            int'({rx_valid, rx_timeout, rx_active}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table of loopback vectors
        for (int i = 0; i < 8; i++) begin
            nm = VEC[i][20];
            p  = VEC[i][19:8];
            b  = VEC[i][7:0];
            peff = (p < 12'd8) ? 8 : int'(p);
            nb   = nm ? 10 : 8;
            if (nm) repeat (80) @(negedge clk);
            v0 = vcount;
            send(nm, p, b, -1, bc, dc);
            repeat (4) @(negedge clk);
            chk(bc == nb * peff, "R3 R4 busy length", bc, nb * peff);
            chk(dc == 1, "R6 done one cycle", dc, 1);
            chk(last_high == (b[0] ? peff - peff / 4 : peff / 4), "R2 last bit high time",
                last_high, b[0] ? peff - peff / 4 : peff / 4);
            chk(vcount == v0 + 1, "R9 one byte strobe", vcount, v0 + 1);
            chk(last_byte == b, "R5 R9 byte value", int'(last_byte), int'(b));
            chk(int'(rx_period) == peff, nm ? "R8 measured period" : "R10 period reused",
                int'(rx_period), peff);
        end

        // R7: start while busy is ignored
        repeat (80) @(negedge clk);
        v0 = vcount;
        send(1'b1, 12'd10, 8'h96, 20, bc, dc);
        repeat (4) @(negedge clk);
        chk(bc == 100, "R7 busy length unchanged", bc, 100);
        chk(last_byte == 8'h96, "R7 byte unchanged", int'(last_byte), 'h96);
        chk(vcount == v0 + 1, "R7 single byte", vcount, v0 + 1);
        repeat (80) @(negedge clk);

        // R11: byte cut short after three bits
        use_ext = 1'b1;
        ext_line = 1'b0;
        repeat (10) @(negedge clk);
        v0 = vcount;
        t0 = tocount;
        ext_bit(10, 0); ext_bit(10, 0);
        ext_bit(10, 1); ext_bit(10, 0); ext_bit(10, 1);
        ext_line = 1'b0;
        repeat (40) @(negedge clk);
        chk(tocount == t0 + 1, "R11 timeout strobe", tocount, t0 + 1);
        chk(vcount == v0, "R11 partial byte dropped", vcount, v0);
        chk(rx_active == 0, "R11 back to idle", int'(rx_active), 0);

        // R12: clean end at a byte boundary, new period measured
        v0 = vcount;
        t0 = tocount;
        ext_bit(16, 0); ext_bit(16, 0);
        for (int k = 7; k >= 0; k--) ext_bit(16, 1'((8'hC6 >> k) & 1));
        ext_line = 1'b0;
        repeat (60) @(negedge clk);
        chk(vcount == v0 + 1 && last_byte == 8'hC6, "R12 byte before close",
            int'(last_byte), 'hC6);
        chk(tocount == t0, "R12 no timeout", tocount, t0);
        chk(rx_period == 12'd16, "R12 period re-measured", int'(rx_period), 16);
        chk(rx_active == 0, "R12 idle after close", int'(rx_active), 0);

        finish_run();
    end
endmodule